// File: doc/BRIEF.md
# Byte-Match Watchdog Timer

This block is a watchdog built around a free-running 16-bit count, split into a low byte and a high byte, and an 8-bit compare value. Software services it by writing to a reload address. On that write the compare value takes the current high byte plus a programmed offset byte. A reset pulse is raised when the low byte rolls over while the high byte equals the compare value. The deadline therefore lies a whole number of low-byte periods ahead. The distance to the first of those periods depends on where the low byte stood at the reload.

The count advances on a clock enable taken from the system clock. The enable is the system clock divided by twelve, divided by four, or undivided. While the CPU reports idle, a control bit can freeze the count. A control write can turn the watchdog off. A separate lock bit keeps it on until the next reset. A force write raises the reset at once. The reset pulse puts every register of the block back to its power-on value.

Register writes use a 2-bit address:
- 0: control. Bits 2:0 select the clock, bit 3 is the idle-freeze bit, bit 4 is enable, bit 5 is lock.
- 1: the offset byte.
- 2: reload. The data is ignored.
- 3: force. Only bit 0 is used.

Top module: `cmp_wdog`

## Requirements
- R1: After reset the watchdog is enabled, the clock selects divide-by-12, and the count, offset and compare value are zero. The first pulse is registered on the 3072nd clock edge after reset is released.
- R2: A write to address 2 while enabled loads the compare value with (high byte + offset) mod 256. The pulse then follows after 256*offset + 256 - L count ticks, where L is the low byte just after the write. A later reload moves the deadline.
- R3: A pulse is raised only when the low byte goes from 0xFF to 0x00 while the high byte equals the compare value and the watchdog is enabled. The pulse lasts one cycle and is registered on the edge of that rollover.
- R4: Control bits 2:0 select the count rate. Code 0 gives one tick per 12 clocks, code 1 one tick per 4 clocks, and code 2 one tick per clock.
- R5: A write to address 3 with data bit 0 = 1 while enabled registers a pulse on the edge of that write. With bit 0 = 0 the write has no effect.
- R6: With control bit 4 clear and no lock, the watchdog is disabled. Rollovers, reload writes and force writes then produce no pulse.
- R7: Control bit 5 sets a lock. While it is set the watchdog stays enabled whatever bit 4 holds, and a control write cannot clear it.
- R8: While the watchdog is enabled, control writes leave the clock select and the idle-freeze bit unchanged.
- R9: With control bit 3 set, the count and its divider hold in every cycle in which `cpu_idle` is high.
- R10: A pulse returns the count, divider, lock, enable, offset, compare value and control fields to their reset values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 offset, 2 reload, 3 force) |
| wr_data | input | 8 | Write data |
| cpu_idle | input | 1 | CPU idle indication |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest case to reach is a reload at a low-byte phase other than zero. The expected deadline then depends on both the offset and the exact count value at the write. The stimulus switches to the undivided clock in a fixed sequence of writes right after reset, so the low byte after every edge is a known function of the edge number. Reloads are then placed at chosen edges, including a second reload that moves the deadline once the high byte has advanced. The idle-freeze case uses the same approach with a 100-cycle idle window: a frozen count shifts the pulse by exactly that many edges. The lock case uses a single control write that tries to change the clock select and clear enable together.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_OFFS  = 2'd1;
  localparam logic [ADDR_W-1:0] A_KICK  = 2'd2;
  localparam logic [ADDR_W-1:0] A_FORCE = 2'd3;

  localparam int unsigned SEL_W  = 3;
  localparam int unsigned F_SEL  = 0;
  localparam int unsigned F_IDLE = 3;
  localparam int unsigned F_EN   = 4;
  localparam int unsigned F_LOCK = 5;

  typedef enum logic [SEL_W-1:0] {
    SRC_SLOW = 3'd0,
    SRC_MID  = 3'd1,
    SRC_FULL = 3'd2
  } src_e;

  // clocks per count tick for a select code
  function automatic int unsigned src_divisor(logic [SEL_W-1:0] sel,
                                              int unsigned slow,
                                              int unsigned mid);
    case (sel)
      SRC_MID:  return mid;
      SRC_FULL: return 1;
      default:  return slow;
    endcase
  endfunction

endpackage

// File: rtl/cwd_prescale.sv
module cwd_prescale
  import cwd_pkg::*;
#(
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_MID  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             hold,
  output logic             tick
);
  localparam int unsigned PW = $clog2(DIV_SLOW);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_comb lim = PW'(src_divisor(sel, DIV_SLOW, DIV_MID) - 1);

  // >= lets a switch to a shorter divisor end the current period at once
  assign tick = !hold && (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pcnt <= '0;
    else if (tick)         pcnt <= '0;
    else if (!hold)        pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/cwd_count.sv
module cwd_count #(
  parameter int unsigned LOW_W  = 8,
  parameter int unsigned HIGH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  output logic [LOW_W-1:0]  low,
  output logic [HIGH_W-1:0] high,
  output logic              low_wrap
);
  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;

  assign low_wrap = tick && (&low_q);
  assign low      = low_q;
  assign high     = high_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (tick) begin
      low_q <= low_q + 1'b1;
      if (&low_q) high_q <= high_q + 1'b1;
    end
  end
endmodule

// File: rtl/cwd_regs.sv
module cwd_regs
  import cwd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned HIGH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [HIGH_W-1:0] high,
  output logic [SEL_W-1:0]  sel,
  output logic              idle_sus,
  output logic              en_eff,
  output logic              lock,
  output logic [HIGH_W-1:0] offs,
  output logic [HIGH_W-1:0] cmp,
  output logic              kick_ok,
  output logic              force_req
);
  logic en_q;

  function automatic logic [HIGH_W-1:0] next_cmp(logic [HIGH_W-1:0] h,
                                                 logic [HIGH_W-1:0] o);
    return h + o;
  endfunction

  assign en_eff    = en_q || lock;
  assign kick_ok   = wr_en && (wr_addr == A_KICK) && en_eff;
  assign force_req = wr_en && (wr_addr == A_FORCE) && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      en_q     <= 1'b1;
      lock     <= 1'b0;
      sel      <= SRC_SLOW;
      idle_sus <= 1'b0;
      offs     <= '0;
      cmp      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          en_q <= wr_data[F_EN];
          lock <= lock | wr_data[F_LOCK];
          if (!en_eff) begin
            sel      <= wr_data[F_SEL +: SEL_W];
            idle_sus <= wr_data[F_IDLE];
          end
        end
        A_OFFS: offs <= wr_data[HIGH_W-1:0];
        A_KICK: if (en_eff) cmp <= next_cmp(high, offs);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmp_wdog.sv
module cmp_wdog
  import cwd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOW_W    = 8,
  parameter int unsigned HIGH_W   = 8,
  parameter int unsigned DIV_SLOW = 12,
  parameter int unsigned DIV_MID  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_idle,
  output logic              wdt_rst
);
  logic              tick, hold, low_wrap, match_wrap, fire;
  logic              en_eff, lock, idle_sus, kick_ok, force_req;
  logic [SEL_W-1:0]  sel;
  logic [LOW_W-1:0]  low;
  logic [HIGH_W-1:0] high, offs, cmp;

  assign hold       = idle_sus && cpu_idle;
  assign match_wrap = low_wrap && (high == cmp);
  assign fire       = en_eff && (match_wrap || force_req);

  cwd_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(fire), .sel(sel), .hold(hold), .tick(tick)
  );

  cwd_count #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(fire), .tick(tick),
    .low(low), .high(high), .low_wrap(low_wrap)
  );

  cwd_regs #(.DATA_W(DATA_W), .HIGH_W(HIGH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .restart(fire), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .high(high), .sel(sel), .idle_sus(idle_sus),
    .en_eff(en_eff), .lock(lock), .offs(offs), .cmp(cmp),
    .kick_ok(kick_ok), .force_req(force_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) wdt_rst <= 1'b0;
    else        wdt_rst <= fire;
  end
endmodule

// File: rtl/cwd_checker.sv
module cwd_checker
  import cwd_pkg::*;
#(
  parameter int unsigned LOW_W  = 8,
  parameter int unsigned HIGH_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wdt_rst,
  input logic              cpu_idle,
  input logic              en_eff,
  input logic              lock,
  input logic              idle_sus,
  input logic              kick_ok,
  input logic              match_wrap,
  input logic [SEL_W-1:0]  sel,
  input logic [LOW_W-1:0]  low,
  input logic [HIGH_W-1:0] high,
  input logic [HIGH_W-1:0] offs,
  input logic [HIGH_W-1:0] cmp
);
  p_reload_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (wdt_rst || cmp == HIGH_W'($past(high) + $past(offs))));

  p_wrap_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_eff && match_wrap) |=> wdt_rst);

  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_eff |=> !wdt_rst);

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> (lock || wdt_rst));

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_eff |=> (wdt_rst || ($stable(sel) && $stable(idle_sus))));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_sus && cpu_idle) |=> (wdt_rst || ($stable(low) && $stable(high))));

  p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (low == '0 && high == '0 && cmp == '0 && offs == '0 &&
                 !lock && en_eff && sel == SRC_SLOW && !idle_sus));
endmodule

bind cmp_wdog cwd_checker #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .cpu_idle(cpu_idle),
  .en_eff(en_eff), .lock(lock), .idle_sus(idle_sus), .kick_ok(kick_ok),
  .match_wrap(match_wrap), .sel(sel), .low(low), .high(high),
  .offs(offs), .cmp(cmp)
);

// File: tb/cmp_wdog_tb_top.sv
module cmp_wdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 150000;

  typedef struct {
    int unsigned at;
    string       req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cpu_idle = 1'b0;
  logic       wdt_rst;

  int unsigned edges = 0;
  int          checks = 0;
  int          errors = 0;
  int          npulse = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  exp_t        sb[$];

  cmp_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_idle(cpu_idle), .wdt_rst(wdt_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: compares each pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wdt_rst) begin
        npulse++;
        if (sb.size() == 0) check(1'b0, "R6", "unexpected pulse at edge", int'(edges), -1);
        else begin
          check(edges == sb[0].at, sb[0].req, "pulse edge", int'(edges), int'(sb[0].at));
          void'(sb.pop_front());
        end
      end
      if (sb.size() > 0 && edges > sb[0].at) begin
        check(1'b0, sb[0].req, "missed pulse", int'(edges), int'(sb[0].at));
        void'(sb.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      done = 1'b1;
      check(1'b0, "R1", "watchdog expired", cyc, MAX_CYC);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic expect_pulse(input int unsigned at, input string req);
    exp_t e;
    e.at = at;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cpu_idle = 1'b0;
    repeat (3) @(negedge clk);
    check(wdt_rst == 1'b0, "R1", "pulse low in reset", int'(wdt_rst), 0);
    sb.delete();
    npulse = 0;
    rst_n = 1'b1;
  endtask

  task automatic wr(input int unsigned at, input logic [1:0] a, input logic [7:0] d);
    while (edges != at - 1) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int unsigned at, input int n, input string req);
    while (edges != at) @(negedge clk);
    check(npulse == n, req, "pulse count", npulse, n);
    check(sb.size() == 0, req, "pending expectations", sb.size(), 0);
  endtask

  // switch to one tick per clock and enable; low byte after edge e is e-2
  task automatic full_rate_setup(input logic [7:0] off);
    wr(1, 2'd0, 8'h00);
    wr(2, 2'd0, 8'h02);
    wr(3, 2'd1, off);
    wr(4, 2'd0, 8'h12);
  endtask

  initial begin
    // R1, R10: defaults give 3072 clocks, and again after the pulse
    do_reset();
    expect_pulse(3072, "R1");
    expect_pulse(6144, "R10");
    settle(6200, 2, "R1");

    // R2, R4 (code 2): offset 3, reload at edge 5 -> 258 + 3*256
    do_reset();
    full_rate_setup(8'd3);
    expect_pulse(1026, "R2");
    expect_pulse(4098, "R10");
    wr(5, 2'd2, 8'hA5);
    settle(4200, 2, "R2");

    // R2, R3: reload at low=98 (deadline 514), again at edge 400 (moves to 770)
    do_reset();
    full_rate_setup(8'd1);
    expect_pulse(770, "R2");
    expect_pulse(3842, "R3");
    wr(100, 2'd2, 8'h00);
    wr(400, 2'd2, 8'h00);
    settle(4000, 2, "R2");

    // R6: disabled, reload and force ignored, rollovers at 3072/6144 quiet
    do_reset();
    wr(1, 2'd0, 8'h00);
    wr(2, 2'd1, 8'h05);
    wr(100, 2'd2, 8'h00);
    wr(200, 2'd3, 8'h01);
    settle(7000, 0, "R6");

    // R7, R8: lock with bit4 clear and a clock-select change; both ignored
    do_reset();
    expect_pulse(3072, "R7");
    wr(1, 2'd0, 8'h22);
    wr(2, 2'd0, 8'h00);
    wr(3100, 2'd0, 8'h00);  // R10: lock gone after the pulse, so this disables
    settle(6500, 1, "R7");

    // R5: force at edge 1, ignored force with bit0=0 at edge 50
    do_reset();
    expect_pulse(1, "R5");
    expect_pulse(3073, "R5");
    wr(1, 2'd3, 8'h01);
    wr(50, 2'd3, 8'hFE);
    settle(3200, 2, "R5");

    // R9, R8: idle freeze for 100 edges shifts 258 to 358; idle bit clear ignored
    do_reset();
    wr(1, 2'd0, 8'h00);
    wr(2, 2'd0, 8'h0A);
    wr(3, 2'd0, 8'h1A);
    wr(4, 2'd2, 8'h00);
    wr(5, 2'd0, 8'h10);
    expect_pulse(358, "R9");
    expect_pulse(3430, "R10");
    while (edges != 10) @(negedge clk);
    cpu_idle = 1'b1;
    repeat (100) @(negedge clk);
    cpu_idle = 1'b0;
    settle(3500, 2, "R9");

    // R4 (code 1): one tick per 4 clocks, first rollover at edge 1024
    do_reset();
    wr(1, 2'd0, 8'h00);
    wr(2, 2'd0, 8'h01);
    wr(3, 2'd0, 8'h11);
    expect_pulse(1024, "R4");
    expect_pulse(4096, "R10");
    settle(4200, 2, "R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule